// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the running count that a pulse-width modulator compares against. A 16-bit counter advances once per prescaled tick. The tick comes from a two-stage divider of the system clock: a power-of-two stage, then a stage that divides by one or by an even number. A two-bit mode selects counting up, counting down, counting up then down (a triangle), or holding the count. The counter runs between zero and an active period value. That value is written either at once or through a shadow copy that takes effect when the count is at zero.

Software writes a control word and a period word through plain write strobes with data. The block reports the count, a direction flag, and two single-cycle events: one when the count is at zero and one when it is at the active period. Compare and action logic downstream turns these into output edges.

Top module: `pwm_tbase`

## Requirements
- R1: Reset leaves count 0, direction flag 0, both events low, mode hold, both divider codes 0, shadowed period loading, and active and shadow period 0.
- R2: Control word fields are mode in bits 1:0 (0 up, 1 down, 2 up-down, 3 hold), load-immediate in bit 3, high-speed code in bits 9:7 and coarse code in bits 12:10. Writing any other bit has no effect on the outputs.
- R3: The tick divides the clock by (2^coarse) x (high-speed code 0 ? 1 : 2 x code). The count changes only on the clock edge that closes a tick cycle.
- R4: A control write that changes either divider code restarts the divider: the next count advance falls on the (ratio+1)-th edge after the edge that stores the write. A write that leaves both codes unchanged does not restart it.
- R5: In up mode each tick adds one, and a count at or above the active period goes to 0.
- R6: In down mode each tick subtracts one, and a count of 0 reloads the active period.
- R7: In up-down mode the count rises to the active period and then falls to 0, reversing at each end without repeating the turning value. With period 0 it stays at 0.
- R8: In hold mode the count and the direction flag do not change.
- R9: The zero event is high for exactly one clock in a tick cycle where the count is 0. The period event is high in a tick cycle where the count equals the active period. Neither is raised in hold mode.
- R10: With load-immediate set, a period write reaches the active period (and the shadow) on the next edge.
- R11: With load-immediate clear, a period write goes to the shadow only. The shadow is copied into the active period on the edge that ends a zero-event cycle.
- R12: The direction flag is 1 while counting down and 0 while counting up. It changes only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word data |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write data |
| cnt | output | 16 | Current count |
| dir_down | output | 1 | 1 when counting down |
| zero_evt | output | 1 | Count-at-zero event pulse |
| prd_evt | output | 1 | Count-at-period event pulse |

## Verification
If the divider's internal count goes wrong, the counter advances on the wrong edge. This shows at the ports within one divide period, and it appears first right after a code change, where the restart timing is exact. A wrong shadow or active period stays hidden until the next zero crossing. From then on it shows as a wrong wrap point or a period event in the wrong place. A wrong direction state in up-down mode shows on the very next tick as a count that moves the wrong way.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    localparam int TB_CNT_W  = 16;
    localparam int TB_CODE_W = 3;
    localparam int TB_CTL_W  = 16;

    // control word field positions
    localparam int MODE_LSB = 0;
    localparam int LOAD_BIT = 3;
    localparam int HS_LSB   = 7;
    localparam int CRS_LSB  = 10;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2,
        CM_HOLD = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        cnt_mode_e              mode;
        logic                   imm;
        logic [TB_CODE_W-1:0]   hs;
        logic [TB_CODE_W-1:0]   coarse;
    } tb_cfg_t;

    localparam tb_cfg_t CFG_RESET = '{mode: CM_HOLD, imm: 1'b0, hs: '0, coarse: '0};

    function automatic tb_cfg_t decode_ctl(input logic [TB_CTL_W-1:0] w);
        tb_cfg_t c;
        c.mode   = cnt_mode_e'(w[MODE_LSB +: 2]);
        c.imm    = w[LOAD_BIT];
        c.hs     = w[HS_LSB +: TB_CODE_W];
        c.coarse = w[CRS_LSB +: TB_CODE_W];
        return c;
    endfunction

    // second divider stage: 1 for code 0, else twice the code
    function automatic logic [TB_CODE_W:0] hs_factor(input logic [TB_CODE_W-1:0] code);
        return (code == '0) ? (TB_CODE_W+1)'(1) : {code, 1'b0};
    endfunction

endpackage

// File: rtl/pwm_tbase_ctlreg.sv
module pwm_tbase_ctlreg
    import pwm_tbase_pkg::*;
#(
    parameter int CTL_W = TB_CTL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output tb_cfg_t          cfg
);

    tb_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= decode_ctl(wr_data);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pwm_tbase_prescale.sv
module pwm_tbase_prescale
    import pwm_tbase_pkg::*;
#(
    parameter int CODE_W = TB_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] coarse,
    input  logic [CODE_W-1:0] hs,
    output logic              tick
);

    localparam int MAX_CODE  = (1 << CODE_W) - 1;
    localparam int MAX_HS    = 2 * MAX_CODE;
    localparam int MAX_RATIO = MAX_HS << MAX_CODE;
    localparam int PRE_W     = $clog2(MAX_RATIO);

    logic [PRE_W-1:0]  div_cnt;
    logic [PRE_W-1:0]  ratio;
    logic [PRE_W-1:0]  ratio_m1;
    logic [CODE_W-1:0] crs_seen;
    logic [CODE_W-1:0] hs_seen;
    logic              codes_same;

    always_comb begin
        ratio      = PRE_W'(hs_factor(hs)) << coarse;
        ratio_m1   = ratio - PRE_W'(1);
        codes_same = (crs_seen == coarse) && (hs_seen == hs);
        tick       = codes_same && (div_cnt == ratio_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            crs_seen <= '0;
            hs_seen  <= '0;
        end else begin
            crs_seen <= coarse;
            hs_seen  <= hs;
            if (!codes_same || tick) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tbase_period.sv
module pwm_tbase_period
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = TB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             imm,
    input  logic             load_zero,
    output logic [CNT_W-1:0] prd_act
);

    logic [CNT_W-1:0] prd_shadow;
    logic [CNT_W-1:0] prd_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_shadow <= '0;
            prd_live   <= '0;
        end else if (wr_en && imm) begin
            prd_shadow <= wr_data;
            prd_live   <= wr_data;
        end else begin
            if (load_zero) begin
                prd_live <= prd_shadow;
            end
            if (wr_en) begin
                prd_shadow <= wr_data;
            end
        end
    end

    assign prd_act = prd_live;

endmodule

// File: rtl/pwm_tbase_counter.sv
module pwm_tbase_counter
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = TB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             zero_hit,
    output logic             prd_hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             run;
    logic             at_zero;
    logic             at_top;

    always_comb begin
        run      = tick && (mode != CM_HOLD);
        at_zero  = (cnt_q == '0);
        at_top   = (cnt_q >= prd);
        zero_hit = run && at_zero;
        prd_hit  = run && (cnt_q == prd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (run) begin
            unique case (mode)
                CM_UP: begin
                    dir_q <= 1'b0;
                    cnt_q <= at_top ? '0 : cnt_q + ONE;
                end
                CM_DOWN: begin
                    dir_q <= 1'b1;
                    cnt_q <= at_zero ? prd : cnt_q - ONE;
                end
                CM_UPDN: begin
                    if (!dir_q) begin
                        if (at_top) begin
                            dir_q <= 1'b1;
                            cnt_q <= at_zero ? '0 : cnt_q - ONE;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end else begin
                        if (at_zero) begin
                            dir_q <= 1'b0;
                            cnt_q <= (prd == '0) ? '0 : ONE;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    cnt_q <= cnt_q;
                end
            endcase
        end
    end

    assign cnt      = cnt_q;
    assign dir_down = dir_q;

endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W  = TB_CNT_W,
    parameter int CODE_W = TB_CODE_W,
    parameter int CTL_W  = TB_CTL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             zero_evt,
    output logic             prd_evt
);

    tb_cfg_t          cfg;
    logic             tick;
    logic [1:0]       cur_mode;
    logic             load_imm;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             zero_hit;
    logic             prd_hit;

    pwm_tbase_ctlreg #(.CTL_W(CTL_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .cfg     (cfg)
    );

    pwm_tbase_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .coarse (cfg.coarse),
        .hs     (cfg.hs),
        .tick   (tick)
    );

    pwm_tbase_period #(.CNT_W(CNT_W)) u_prd (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (prd_we),
        .wr_data   (prd_wdata),
        .imm       (cfg.imm),
        .load_zero (zero_hit),
        .prd_act   (prd_act)
    );

    pwm_tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (cfg.mode),
        .prd      (prd_act),
        .cnt      (cnt_q),
        .dir_down (dir_q),
        .zero_hit (zero_hit),
        .prd_hit  (prd_hit)
    );

    assign cur_mode = cfg.mode;
    assign load_imm = cfg.imm;
    assign cnt      = cnt_q;
    assign dir_down = dir_q;
    assign zero_evt = zero_hit;
    assign prd_evt  = prd_hit;

endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [1:0]       mode,
    input logic             imm,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] prd_act,
    input logic             dir_down,
    input logic             zero_evt,
    input logic             prd_evt,
    input logic             prd_we,
    input logic [CNT_W-1:0] prd_wdata
);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_up_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 2'd0 && cnt < prd_act) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_down_step_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 2'd1 && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_hold_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> ($stable(cnt) && $stable(dir_down)));

    assert_events_both_R9: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && prd_evt) |-> (prd_act == '0));

    assert_imm_load_R10: assert property (@(posedge clk) disable iff (rst)
        (prd_we && imm) |=> (prd_act == $past(prd_wdata)));

    assert_shadow_only_R11: assert property (@(posedge clk) disable iff (rst)
        (prd_we && !imm && !zero_evt) |=> $stable(prd_act));

    assert_dir_on_down_R12: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 2'd1) |=> dir_down);

endmodule

bind pwm_tbase pwm_tbase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (cur_mode),
    .imm       (load_imm),
    .cnt       (cnt_q),
    .prd_act   (prd_act),
    .dir_down  (dir_q),
    .zero_evt  (zero_hit),
    .prd_evt   (prd_hit),
    .prd_we    (prd_we),
    .prd_wdata (prd_wdata)
);

// File: tb/pwm_tbase_tb.sv
`timescale 1ns/1ps
module pwm_tbase_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        prd_we = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] cnt;
    logic        dir_down;
    logic        zero_evt;
    logic        prd_evt;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string phase    = "R1";

    always #2 clk = ~clk;

    pwm_tbase u_dut (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .prd_we    (prd_we),
        .prd_wdata (prd_wdata),
        .cnt       (cnt),
        .dir_down  (dir_down),
        .zero_evt  (zero_evt),
        .prd_evt   (prd_evt)
    );

    // behavioural reference model
    int m_cnt, m_dir, m_pre, m_prd, m_sh, m_mode, m_imm, m_n, m_m, m_pn, m_pm;

    function automatic int m_ratio();
        return ((m_m == 0) ? 1 : 2 * m_m) * (1 << m_n);
    endfunction

    function automatic bit m_tick();
        return (m_n == m_pn) && (m_m == m_pm) && (m_pre == m_ratio() - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_dir = 0; m_pre = 0; m_prd = 0; m_sh = 0;
            m_mode = 3; m_imm = 0; m_n = 0; m_m = 0; m_pn = 0; m_pm = 0;
        end else begin
            bit tk, ld, same;
            tk   = m_tick();
            same = (m_n == m_pn) && (m_m == m_pm);
            ld   = tk && (m_mode != 3) && (m_cnt == 0);
            if (tk && m_mode != 3) begin
                if (m_mode == 0) begin
                    m_dir = 0;
                    m_cnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
                end else if (m_mode == 1) begin
                    m_dir = 1;
                    m_cnt = (m_cnt == 0) ? m_prd : m_cnt - 1;
                end else if (m_dir == 0) begin
                    if (m_cnt >= m_prd) begin
                        m_dir = 1;
                        m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                    end else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        m_dir = 0;
                        m_cnt = (m_prd == 0) ? 0 : 1;
                    end else m_cnt = m_cnt - 1;
                end
            end
            if (prd_we && m_imm == 1) begin
                m_prd = prd_wdata; m_sh = prd_wdata;
            end else begin
                if (ld) m_prd = m_sh;
                if (prd_we) m_sh = prd_wdata;
            end
            m_pre = (!same || tk) ? 0 : m_pre + 1;
            m_pn = m_n; m_pm = m_m;
            if (ctl_we) begin
                m_mode = ctl_wdata[1:0];
                m_imm  = ctl_wdata[3];
                m_m    = ctl_wdata[9:7];
                m_n    = ctl_wdata[12:10];
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ez, ep;
            ez = m_tick() && m_mode != 3 && m_cnt == 0;
            ep = m_tick() && m_mode != 3 && m_cnt == m_prd;
            check(phase, cnt, m_cnt, "cnt");
            check(phase, dir_down, m_dir, "dir_down");
            check(phase, zero_evt, ez, "zero_evt");
            check(phase, prd_evt, ep, "prd_evt");
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [15:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_prd(input logic [15:0] p);
        @(negedge clk);
        prd_we = 1'b1; prd_wdata = p;
        @(negedge clk);
        prd_we = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", cnt, 0, "cnt after reset");
        check("R1", dir_down, 0, "dir after reset");
        check("R1", zero_evt, 0, "zero_evt after reset");
        check("R1", prd_evt, 0, "prd_evt after reset");
        run(5);

        phase = "R5";
        wr_ctl(16'h0008);           // up, immediate load, ratio 1
        wr_prd(16'd5);
        run(20);

        phase = "R2";
        wr_ctl(16'hE07C);           // same fields plus unused bits set
        run(12);

        phase = "R6";
        wr_ctl(16'h0009);
        run(20);

        phase = "R7";
        wr_ctl(16'h000A);
        run(30);

        phase = "R12";
        wr_ctl(16'h0009);
        run(4);
        wr_ctl(16'h000A);
        run(12);

        phase = "R8";
        wr_ctl(16'h000B);
        run(10);

        phase = "R3";
        wr_ctl(16'h0988);           // coarse 2, high-speed 3: ratio 24
        run(200);

        phase = "R4";
        begin
            int k;
            logic [15:0] c0;
            @(negedge clk);
            ctl_we = 1'b1; ctl_wdata = 16'h0488;   // coarse 1, high-speed 1: ratio 4
            @(posedge clk);
            @(negedge clk);
            ctl_we = 1'b0;
            c0 = cnt;
            k = 1;
            for (int i = 0; i < 50; i++) begin
                @(posedge clk);
                k++;
                @(negedge clk);
                if (cnt != c0) break;
            end
            check("R4", k, 6, "edge of first advance after code change");
        end
        run(20);
        wr_ctl(16'h048A);           // mode change only, codes kept
        run(20);

        phase = "R11";
        wr_ctl(16'h0000);           // up, shadow load, ratio 1
        run(3);
        wr_prd(16'd9);
        run(30);
        wr_ctl(16'h0002);
        wr_prd(16'd2);
        run(30);

        phase = "R10";
        wr_ctl(16'h0008);
        wr_prd(16'd12);
        run(8);
        wr_prd(16'd3);
        run(20);

        phase = "R9";
        wr_prd(16'd0);
        run(6);
        wr_ctl(16'h000A);
        run(6);
        wr_ctl(16'h0009);
        wr_prd(16'hFFFF);
        run(10);
        wr_ctl(16'h0008);
        run(10);

        done = 1;
        summary();
        $finish;
    end

endmodule